// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame whose destination address is a group (multicast) address should be kept. The receive path hands it the six destination address bytes one per cycle. The first byte is marked with a start flag. Over those bytes the block runs a byte-serial, LSB-first Ethernet CRC-32. It turns the result into a 6-bit table index and looks that index up in a 64-bit hash table. One cycle after the sixth byte it raises a one-cycle done pulse, together with a hit flag and the index it used.

The 64-bit table is held as two 32-bit words. Host logic can load or read either word through a small register port. It can also add an address by OR-ing a single bit into the table by index. Both words clear on reset, so every address misses until the table has been programmed.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset both table words read as zero, `mc_done` is low, and every address misses until a table bit has been set.
- R2: The CRC register is preset to 0xFFFFFFFF and fed bytes in arrival order, each byte least significant bit first, with the reflected polynomial 0xEDB88320 and no final inversion. `mc_index` is the top six bits of the bit-reversed CRC: `mc_index[5]` = CRC bit 0, and `mc_index[4:0]` = CRC bits 1..5 with CRC bit 1 as the most significant.
- R3: Table bit `mc_index` is looked up with bit 5 choosing the word (0 = `reg_sel` 0) and bits 4:0 choosing the bit in it, so the table acts as one 64-bit array with word 0 holding indices 0..31. `mc_hit` equals that bit.
- R4: `mc_done` pulses high for exactly one cycle, in the cycle after the clock edge that accepts the sixth byte.
- R5: A byte with `da_valid` and `da_first` both high always starts a new computation from the preset value with that byte as byte one. Any computation in progress is dropped.
- R6: A byte with `da_valid` high and `da_first` low is ignored when no computation is in progress, and produces no done pulse.
- R7: `reg_wr` replaces table word `reg_sel` with `reg_wdata` at the clock edge. `reg_rdata` always shows table word `reg_sel`.
- R8: `set_en` ORs table bit `set_idx` (word `set_idx[5]`, bit `set_idx[4:0]`) into the table and changes no other bit. When it coincides with a write to the same word, the written data is kept with that bit also set.
- R9: `mc_hit` is low in every cycle where `mc_done` is low.
- R10: Cycles with `da_valid` low between bytes pause the computation without losing progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_valid | input | 1 | Address byte present |
| da_first | input | 1 | Byte is the first of an address |
| da_byte | input | 8 | Destination address byte |
| mc_done | output | 1 | One-cycle pulse: result valid |
| mc_hit | output | 1 | Table bit for the address (with done) |
| mc_index | output | 6 | Table index of the address (with done) |
| reg_sel | input | 1 | Table word select for read and write |
| reg_wr | input | 1 | Load selected word |
| reg_wdata | input | 32 | Word load data |
| reg_rdata | output | 32 | Selected table word |
| set_en | input | 1 | Set one table bit |
| set_idx | input | 6 | Index of the bit to set |

## Verification
The bench builds the block with its default parameters: six address bytes and two 32-bit words. This makes the full 6-bit index space reachable, so both words and every bit position within them can be exercised. With these values the reversal that gives bit 5 the word select and bits 4:0 the bit position is tested exactly as the table layout depends on it. The stimulus includes back-to-back addresses, where one done pulse coincides with the next start. It also includes restarts at every depth up to the fifth byte, stray bytes while idle, and a write and a bit set landing on the same word in the same cycle.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    localparam int          CRC_W         = 32;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;
endpackage

// File: rtl/mcf_crc_step.sv
// One byte of reflected CRC-32, bits consumed LSB first.
module mcf_crc_step
    import mcf_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [BYTE_W:0][CRC_W-1:0] stage;

    assign stage[0] = crc_i;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        assign stage[g+1] = (stage[g] >> 1) ^
                            ((stage[g][0] ^ data_i[g]) ? CRC_POLY_REFL : '0);
    end

    assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/mcf_addr_seq.sv
// Byte counter and CRC accumulator; emits a done pulse with the table index.
module mcf_addr_seq
    import mcf_pkg::*;
#(
    parameter  int BYTE_W     = 8,
    parameter  int ADDR_BYTES = 6,
    parameter  int IDX_W      = 6,
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld_i,
    input  logic              byte_first_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              done_o,
    output logic [IDX_W-1:0]  idx_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic             done;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    logic             restart;
    logic             take;
    logic [CRC_W-1:0] crc_base;
    logic [CRC_W-1:0] crc_next;
    logic [CNT_W-1:0] cnt_next;

    assign restart  = byte_vld_i & byte_first_i;
    assign take     = byte_vld_i & (byte_first_i | s_q.busy);
    assign crc_base = restart ? CRC_PRESET : s_q.crc;
    assign cnt_next = restart ? CNT_W'(1) : s_q.cnt + CNT_W'(1);

    mcf_crc_step #(.BYTE_W(BYTE_W)) crc_step_i (
        .crc_i  (crc_base),
        .data_i (byte_i),
        .crc_o  (crc_next)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (take) begin
            s_d.busy = 1'b1;
            s_d.cnt  = cnt_next;
            s_d.crc  = crc_next;
            if (cnt_next == CNT_W'(ADDR_BYTES)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                // top bits of the end-to-end reversed CRC
                for (int k = 0; k < IDX_W; k++) begin
                    s_d.idx[IDX_W-1-k] = crc_next[k];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, cnt: '0, crc: CRC_PRESET, done: 1'b0, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = s_q.done;
    assign idx_o  = s_q.idx;
endmodule

// File: rtl/mcf_hash_table.sv
// Bit table split into host-visible words; word w holds indices w*WORD_W upward.
module mcf_hash_table #(
    parameter  int WORD_W  = 32,
    parameter  int N_WORDS = 2,
    localparam int IDX_W   = $clog2(WORD_W * N_WORDS),
    localparam int BIT_W   = $clog2(WORD_W),
    localparam int SEL_W   = IDX_W - BIT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SEL_W-1:0]          sel_i,
    input  logic                      wr_i,
    input  logic [WORD_W-1:0]         wdata_i,
    output logic [WORD_W-1:0]         rdata_o,
    input  logic                      set_i,
    input  logic [IDX_W-1:0]          set_idx_i,
    input  logic                      look_i,
    input  logic [IDX_W-1:0]          look_idx_i,
    output logic                      hit_o,
    output logic [WORD_W*N_WORDS-1:0] tbl_o
);
    typedef struct packed {
        logic [N_WORDS-1:0][WORD_W-1:0] word;
    } tbl_t;

    tbl_t t_d, t_q;

    logic [SEL_W-1:0] set_word;
    logic [BIT_W-1:0] set_bit;

    assign set_word = set_idx_i[IDX_W-1:BIT_W];
    assign set_bit  = set_idx_i[BIT_W-1:0];

    always_comb begin
        t_d = t_q;
        for (int w = 0; w < N_WORDS; w++) begin
            if (wr_i && sel_i == SEL_W'(w)) begin
                t_d.word[w] = wdata_i;
            end
            if (set_i && set_word == SEL_W'(w)) begin
                t_d.word[w][set_bit] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_flat
        assign tbl_o[w*WORD_W +: WORD_W] = t_q.word[w];
    end

    assign rdata_o = t_q.word[sel_i];
    assign hit_o   = look_i & tbl_o[look_idx_i];
endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter #(
    parameter  int BYTE_W     = 8,
    parameter  int ADDR_BYTES = 6,
    parameter  int WORD_W     = 32,
    parameter  int N_WORDS    = 2,
    localparam int IDX_W      = $clog2(WORD_W * N_WORDS),
    localparam int SEL_W      = IDX_W - $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              da_valid,
    input  logic              da_first,
    input  logic [BYTE_W-1:0] da_byte,
    output logic              mc_done,
    output logic              mc_hit,
    output logic [IDX_W-1:0]  mc_index,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx
);
    logic                      seq_done;
    logic [IDX_W-1:0]          seq_idx;
    logic [WORD_W*N_WORDS-1:0] tbl_flat;

    mcf_addr_seq #(
        .BYTE_W     (BYTE_W),
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld_i   (da_valid),
        .byte_first_i (da_first),
        .byte_i       (da_byte),
        .done_o       (seq_done),
        .idx_o        (seq_idx)
    );

    mcf_hash_table #(
        .WORD_W  (WORD_W),
        .N_WORDS (N_WORDS)
    ) tbl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (reg_sel),
        .wr_i       (reg_wr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .set_i      (set_en),
        .set_idx_i  (set_idx),
        .look_i     (seq_done),
        .look_idx_i (seq_idx),
        .hit_o      (mc_hit),
        .tbl_o      (tbl_flat)
    );

    assign mc_done  = seq_done;
    assign mc_index = seq_idx;
endmodule

// File: rtl/mcf_checker.sv
module mcf_checker #(
    parameter int ADDR_BYTES = 6,
    parameter int WORD_W     = 32,
    parameter int N_WORDS    = 2,
    parameter int IDX_W      = 6,
    parameter int SEL_W      = 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      da_valid,
    input logic                      da_first,
    input logic                      mc_done,
    input logic                      mc_hit,
    input logic [SEL_W-1:0]          reg_sel,
    input logic                      reg_wr,
    input logic [WORD_W-1:0]         reg_wdata,
    input logic                      set_en,
    input logic [IDX_W-1:0]          set_idx,
    input logic [WORD_W*N_WORDS-1:0] tbl_flat
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (tbl_flat == '0));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mc_done |=> !mc_done);

    p_done_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mc_done |-> $past(da_valid));

    p_restart_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ADDR_BYTES > 1 && da_valid && da_first) |=> !mc_done);

    p_load_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !set_en) |=>
            (tbl_flat[$past(reg_sel)*WORD_W +: WORD_W] == $past(reg_wdata)));

    p_set_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !reg_wr) |=>
            (((tbl_flat & $past(tbl_flat)) == $past(tbl_flat)) && tbl_flat[$past(set_idx)]));

    p_hit_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_done |-> !mc_hit);
endmodule

bind mc_hash_filter mcf_checker #(
    .ADDR_BYTES (ADDR_BYTES),
    .WORD_W     (WORD_W),
    .N_WORDS    (N_WORDS),
    .IDX_W      (IDX_W),
    .SEL_W      (SEL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .da_valid  (da_valid),
    .da_first  (da_first),
    .mc_done   (mc_done),
    .mc_hit    (mc_hit),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .set_en    (set_en),
    .set_idx   (set_idx),
    .tbl_flat  (tbl_flat)
);

// File: tb/mc_hash_filter_tb_top.sv
module mc_hash_filter_tb_top;
    localparam int NB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        da_valid = 1'b0;
    logic        da_first = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        mc_done;
    logic        mc_hit;
    logic [5:0]  mc_index;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        set_en = 1'b0;
    logic [5:0]  set_idx = '0;

    int checks = 0;
    int bad = 0;
    int dones = 0;

    always #2 clk = ~clk;

    mc_hash_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .da_valid(da_valid), .da_first(da_first), .da_byte(da_byte),
        .mc_done(mc_done), .mc_hit(mc_hit), .mc_index(mc_index),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .set_en(set_en), .set_idx(set_idx)
    );

    // R2: reflected CRC-32, preset ones, no final inversion, reversed, top six bits
    function automatic logic [5:0] hash48(input logic [47:0] a);
        logic [31:0] c;
        logic [31:0] r;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < NB; i++) begin
            logic [7:0] b;
            b = a[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                logic fb;
                fb = c[0] ^ b[j];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        for (int i = 0; i < 32; i++) r[31-i] = c[i];
        return r[31:26];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model, advanced on every clock edge
    logic [7:0]  mq[$];
    bit          m_busy;
    logic [63:0] mtab;
    bit          e_done;
    logic [5:0]  e_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_busy = 0;
            mtab   = '0;
            e_done = 0;
            e_idx  = '0;
        end else begin
            e_done = 0;
            if (da_valid && da_first) begin
                mq.delete();
                mq.push_back(da_byte);
                m_busy = 1;
            end else if (da_valid && m_busy) begin
                mq.push_back(da_byte);
            end
            if (m_busy && mq.size() == NB) begin
                logic [47:0] a;
                for (int i = 0; i < NB; i++) a[47-8*i -: 8] = mq[i];
                e_done = 1;
                e_idx  = hash48(a);
                m_busy = 0;
                mq.delete();
            end
            if (reg_wr) mtab[32*reg_sel +: 32] = reg_wdata;
            if (set_en) mtab[set_idx] = 1'b1;
        end
        #1;
        chk(mc_done === e_done, "R4/R5/R6/R10 done", 64'(mc_done), 64'(e_done));
        if (e_done) begin
            dones++;
            chk(mc_index === e_idx, "R2 index", 64'(mc_index), 64'(e_idx));
            chk(mc_hit === mtab[e_idx], "R3 hit", 64'(mc_hit), 64'(mtab[e_idx]));
        end else begin
            chk(mc_hit === 1'b0, "R9 hit without done", 64'(mc_hit), 64'd0);
        end
        chk(reg_rdata === mtab[32*reg_sel +: 32], "R1/R7/R8 rdata",
            64'(reg_rdata), 64'(mtab[32*reg_sel +: 32]));
    end

    task automatic send(input logic [47:0] a, input int gap, input int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            da_valid = 1'b1;
            da_first = (i == 0);
            da_byte  = a[47-8*i -: 8];
            reg_sel  = i[0];
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                da_valid = 1'b0;
                da_first = 1'b0;
            end
        end
        @(negedge clk);
        da_valid = 1'b0;
        da_first = 1'b0;
    endtask

    task automatic wr_word(input logic s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_bit(input logic [5:0] idx);
        @(negedge clk);
        set_en = 1'b1; set_idx = idx;
        @(negedge clk);
        set_en = 1'b0;
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [47:0] b;
        logic [47:0] seed;
        int d0;
        // R1: reset state on both words
        repeat (3) @(negedge clk);
        reg_sel = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        reg_sel = 1'b0;
        @(negedge clk);

        // R1: empty table misses
        a = 48'h0100_5E00_0001;
        send(a, 0, NB);
        repeat (2) @(negedge clk);

        // R8, R3: add the address, then it hits
        set_bit(hash48(a));
        send(a, 0, NB);
        b = 48'h3333_0000_00FB;
        send(b, 0, NB);

        // R7, R3, R10: word 1 full, word 0 empty, bytes with gaps
        wr_word(1'b1, 32'hFFFF_FFFF);
        wr_word(1'b0, 32'h0000_0000);
        send(48'h0100_5E7F_FFFA, 2, NB);
        send(48'h0100_5E00_00FC, 1, NB);
        send(48'h0180_C200_0000, 3, NB);

        // R5: restart at every depth short of completion
        for (int k = 1; k < NB; k++) begin
            send(48'h0100_5E12_3456, 0, k);
            send(48'h0100_5E00_0001 + 48'(k), 0, NB);
        end
        // R5: restart with no idle cycle before it
        @(negedge clk);
        da_valid = 1; da_first = 1; da_byte = 8'h01;
        @(negedge clk);
        da_first = 0; da_byte = 8'h00;
        @(negedge clk);
        da_first = 1; da_byte = 8'h01;
        for (int i = 1; i < NB; i++) begin
            @(negedge clk);
            da_first = 0; da_byte = 8'(i * 17);
        end
        @(negedge clk);
        da_valid = 0;

        // R6: stray bytes while idle produce nothing
        d0 = dones;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            da_valid = 1; da_first = 0; da_byte = 8'(i);
        end
        @(negedge clk);
        da_valid = 0;
        repeat (2) @(negedge clk);
        chk(dones == d0, "R6 stray bytes", 64'(dones), 64'(d0));

        // R4: back-to-back addresses, done overlaps next start
        @(negedge clk);
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < NB; i++) begin
                da_valid = 1; da_first = (i == 0); da_byte = 8'(n * 31 + i);
                @(negedge clk);
            end
        end
        da_valid = 0; da_first = 0;
        @(negedge clk);

        // R8: write and set on the same word in the same cycle
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1; reg_wdata = 32'h1234_0000; set_en = 1; set_idx = 6'd3;
        @(negedge clk);
        reg_wr = 0; set_en = 0;
        // R8: set into word 1 keeps the rest
        set_bit(6'd40);
        wr_word(1'b1, 32'h0000_0100);
        set_bit(6'd63);
        reg_sel = 1'b1;
        @(negedge clk);

        // mixed addresses against a sparse table
        seed = 48'h0100_5E5A_A5C3;
        for (int n = 0; n < 40; n++) begin
            seed = {seed[46:0], seed[47] ^ seed[41] ^ seed[26] ^ seed[0]} ^ 48'(n * 7919);
            a = {8'h01, seed[39:0]};
            if (n % 3 == 0) set_bit(hash48(a) ^ 6'd1);
            send(a, n % 3, NB);
        end
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule